// File: doc/BRIEF.md
# Severity-Routed Error Aggregation Unit

This block gathers error indications from five subsystem components into two 32-bit sticky status registers, one for fatal errors and one for non-fatal errors. Each component owns a fixed 6-bit slice of both registers, and most components feed the same raw bits into both slices. A mask register next to each status register then decides which severity a given source actually raises. The two top bits of each register are spare and always read zero.

Two output lines summarise the registers. The fatal line latches on the first unmasked fatal status bit and stays high until the block is reset. The non-fatal line is recomputed every cycle from the non-fatal status and mask. Software reads and writes the four registers over a small register bus: status bits clear when a 1 is written to them, and masks are plain read-write. A separate debug port can read the same four registers but cannot change them.

Top module: `err_sev_aggregator`

## Requirements
- R1: Source routing, with bit 0 as the least significant bit of each status register. `core_err_i` sets bit 0 of both registers. `ecc_dbl_i` sets bit 6 of the fatal register only. `ecc_sgl_i` sets bit 6 of the non-fatal register only. `lc_alert_i[k]` sets bit 12+k of both registers. `fuse_alert_i[k]` sets bit 18+k of both registers. `rst_req_i[k]` sets bit 24+k of both registers. Every other bit, including 31:30, stays 0.
- R2: A status bit stays 1 after its source input returns low, until software clears it.
- R3: A bus write of a 1 to a status bit clears that bit on the next clock edge. A bus write of a 0 leaves the bit unchanged.
- R4: When a source sets a bit in the same cycle as a bus write clears it, the bit ends up 1.
- R5: After reset both status registers read 0, the fatal mask reads 0x3F000000, the non-fatal mask reads 0x00FFF000, and both outputs are low.
- R6: Both mask registers take the full written word and read it back. A mask bit of 1 keeps its status bit from raising the output.
- R7: `fatal_o` goes high one cycle after any fatal status bit with mask 0 is set. Once high, it stays high through status clears and mask writes until reset.
- R8: `nonfatal_o` equals the OR of (non-fatal status AND NOT non-fatal mask), registered one cycle. It falls one cycle after a status or mask write that leaves every bit either cleared or masked.
- R9: Status bits capture even while masked. Writing a 0 to the mask of an already-set bit raises the matching output one cycle after the write.
- R10: The debug port returns the same value as the bus for the same address, and it has no way to write.
- R11: The register addresses are 0 for fatal status, 1 for non-fatal status, 2 for fatal mask and 3 for non-fatal mask. Read data is returned combinationally for the address presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_err_i | input | 1 | Core error, routed to both severities |
| ecc_dbl_i | input | 1 | Double-bit ECC error, fatal side only |
| ecc_sgl_i | input | 1 | Single-bit ECC error, non-fatal side only |
| lc_alert_i | input | LC_W (3) | Lifecycle alerts, routed to both severities |
| fuse_alert_i | input | FUSE_W (5) | Fuse controller alerts, routed to both severities |
| rst_req_i | input | 2 | Reset-request signals, routed to both severities |
| bus_valid_i | input | 1 | Register bus access valid |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| dbg_addr_i | input | 2 | Debug read address |
| dbg_rdata_o | output | 32 | Debug read data |
| fatal_o | output | 1 | Latched fatal error indication |
| nonfatal_o | output | 1 | Live non-fatal error indication |

## Verification
The embedded assertions check several properties on every cycle:
- no status bit falls without a clear write;
- a bit that was set reads 1 on the next cycle, even when a clear hits it in the same cycle;
- the fatal line never falls outside reset;
- an unmasked fatal bit always raises the fatal line;
- the non-fatal line follows its masked status;
- the spare bits stay zero;
- the two read ports agree.

Other behaviour can only be shown by the bench's scenarios. These are the exact source-to-bit routing across all 8192 source combinations, the reset values of the masks, the effect of writing zeros, and the way unmasking a bit that was captured earlier raises an output.

// File: rtl/err_agg_pkg.sv
// Package: shared sizes, register addresses and mask reset values for the
// error aggregation unit. Assumes five fixed regions of REGION_W bits each.
package err_agg_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned REGION_W  = 6;
    localparam int unsigned N_REGIONS = 5;
    localparam int unsigned USED_W    = N_REGIONS * REGION_W;
    localparam int unsigned SPARE_W   = DATA_W - USED_W;
    localparam int unsigned ADDR_W    = 2;

    // Region indices, low to high
    localparam int unsigned RG_CORE = 0;
    localparam int unsigned RG_ECC  = 1;
    localparam int unsigned RG_LC   = 2;
    localparam int unsigned RG_FUSE = 3;
    localparam int unsigned RG_RST  = 4;

    localparam logic [DATA_W-1:0] REGION_ONES = DATA_W'((1 << REGION_W) - 1);

    // Reset-request region is fatal-masked; alert regions are non-fatal-masked
    localparam logic [DATA_W-1:0] FATAL_MASK_RST = REGION_ONES << (RG_RST * REGION_W);
    localparam logic [DATA_W-1:0] NF_MASK_RST    = (REGION_ONES << (RG_LC * REGION_W))
                                                 | (REGION_ONES << (RG_FUSE * REGION_W));

    typedef enum logic [ADDR_W-1:0] {
        A_FATAL_STAT = 2'd0,
        A_NF_STAT    = 2'd1,
        A_FATAL_MASK = 2'd2,
        A_NF_MASK    = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/err_src_map.sv
// Module: err_src_map
// Places each raw source into its fixed region of the fatal and non-fatal
// raw vectors, zero-padding every region. Assumes LC_W and FUSE_W fit a region.
module err_src_map
    import err_agg_pkg::*;
#(
    parameter int unsigned LC_W   = 3,
    parameter int unsigned FUSE_W = 5
) (
    input  logic              core_err_i,
    input  logic              ecc_dbl_i,
    input  logic              ecc_sgl_i,
    input  logic [LC_W-1:0]   lc_alert_i,
    input  logic [FUSE_W-1:0] fuse_alert_i,
    input  logic [1:0]        rst_req_i,
    output logic [DATA_W-1:0] raw_fatal_o,
    output logic [DATA_W-1:0] raw_nf_o
);
    logic [N_REGIONS-1:0][REGION_W-1:0] f_rg;
    logic [N_REGIONS-1:0][REGION_W-1:0] n_rg;

    // Per-region source selection; only the ECC region differs by severity
    for (genvar r = 0; r < N_REGIONS; r++) begin : g_region
        if (r == RG_CORE) begin : g_core
            assign f_rg[r] = REGION_W'(core_err_i);
            assign n_rg[r] = REGION_W'(core_err_i);
        end else if (r == RG_ECC) begin : g_ecc
            assign f_rg[r] = REGION_W'(ecc_dbl_i);
            assign n_rg[r] = REGION_W'(ecc_sgl_i);
        end else if (r == RG_LC) begin : g_lc
            assign f_rg[r] = REGION_W'(lc_alert_i);
            assign n_rg[r] = REGION_W'(lc_alert_i);
        end else if (r == RG_FUSE) begin : g_fuse
            assign f_rg[r] = REGION_W'(fuse_alert_i);
            assign n_rg[r] = REGION_W'(fuse_alert_i);
        end else begin : g_rst
            assign f_rg[r] = REGION_W'(rst_req_i);
            assign n_rg[r] = REGION_W'(rst_req_i);
        end
    end

    // Spare bits tie to zero above the used regions
    assign raw_fatal_o = {{SPARE_W{1'b0}}, f_rg};
    assign raw_nf_o    = {{SPARE_W{1'b0}}, n_rg};
endmodule

// File: rtl/err_sticky_bank.sv
// Module: err_sticky_bank
// W sticky status bits: set by hardware, cleared by write-one; set beats clear.
// Assumes clr_i is already qualified by a write to this register.
module err_sticky_bank #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // Capture sets and apply clears, sets taking priority
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o & ~clr_i) | set_i;
    end

    // R2
    hold_until_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(q_o) & ~$past(clr_i)) & ~q_o) == '0));
    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/err_mask_reg.sv
// Module: err_mask_reg
// Plain read-write mask register with a parameterised reset value.
module err_mask_reg #(
    parameter int unsigned     W   = 32,
    parameter logic [W-1:0]    RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    // Load the full word on write, reset to the default mask
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= RST;
        else if (we_i) q_o <= wdata_i;
    end
endmodule

// File: rtl/err_sev_out.sv
// Module: err_sev_out
// Reduces unmasked status to one output line. LATCH=1 holds the line until
// reset; LATCH=0 recomputes it each cycle. Output is registered in both cases.
module err_sev_out #(
    parameter int unsigned W     = 32,
    parameter bit          LATCH = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] mask_i,
    output logic         err_o
);
    logic any_live;
    // Any status bit not blocked by its mask
    assign any_live = |(stat_i & ~mask_i);

    if (LATCH) begin : g_latch
        // Set on first unmasked bit, hold until reset
        always_ff @(posedge clk) begin
            if (!rst_n) err_o <= 1'b0;
            else        err_o <= err_o | any_live;
        end
        // R7
        latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err_o |=> err_o);
    end else begin : g_live
        // Follow the unmasked status one cycle later
        always_ff @(posedge clk) begin
            if (!rst_n) err_o <= 1'b0;
            else        err_o <= any_live;
        end
    end
endmodule

// File: rtl/err_sev_aggregator.sv
// Module: err_sev_aggregator (top)
// Collects component errors into fatal and non-fatal sticky registers with
// masks, drives the two severity outputs, serves a register bus and a
// read-only debug port. Assumes one bus access per cycle.
module err_sev_aggregator
    import err_agg_pkg::*;
#(
    parameter int unsigned LC_W   = 3,
    parameter int unsigned FUSE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_err_i,
    input  logic              ecc_dbl_i,
    input  logic              ecc_sgl_i,
    input  logic [LC_W-1:0]   lc_alert_i,
    input  logic [FUSE_W-1:0] fuse_alert_i,
    input  logic [1:0]        rst_req_i,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [ADDR_W-1:0] dbg_addr_i,
    output logic [DATA_W-1:0] dbg_rdata_o,
    output logic              fatal_o,
    output logic              nonfatal_o
);
    logic [DATA_W-1:0] raw_f, raw_n;
    logic [DATA_W-1:0] stat_f, stat_n, mask_f, mask_n;
    logic [DATA_W-1:0] clr_f, clr_n;
    logic              wr;

    err_src_map #(.LC_W(LC_W), .FUSE_W(FUSE_W)) i_map (
        .core_err_i   (core_err_i),
        .ecc_dbl_i    (ecc_dbl_i),
        .ecc_sgl_i    (ecc_sgl_i),
        .lc_alert_i   (lc_alert_i),
        .fuse_alert_i (fuse_alert_i),
        .rst_req_i    (rst_req_i),
        .raw_fatal_o  (raw_f),
        .raw_nf_o     (raw_n)
    );

    // Decode bus writes into per-register clear vectors
    assign wr    = bus_valid_i & bus_write_i;
    assign clr_f = (wr && bus_addr_i == A_FATAL_STAT) ? bus_wdata_i : '0;
    assign clr_n = (wr && bus_addr_i == A_NF_STAT)    ? bus_wdata_i : '0;

    err_sticky_bank #(.W(DATA_W)) i_stat_f (
        .clk(clk), .rst_n(rst_n), .set_i(raw_f), .clr_i(clr_f), .q_o(stat_f));
    err_sticky_bank #(.W(DATA_W)) i_stat_n (
        .clk(clk), .rst_n(rst_n), .set_i(raw_n), .clr_i(clr_n), .q_o(stat_n));

    err_mask_reg #(.W(DATA_W), .RST(FATAL_MASK_RST)) i_mask_f (
        .clk(clk), .rst_n(rst_n), .we_i(wr && bus_addr_i == A_FATAL_MASK),
        .wdata_i(bus_wdata_i), .q_o(mask_f));
    err_mask_reg #(.W(DATA_W), .RST(NF_MASK_RST)) i_mask_n (
        .clk(clk), .rst_n(rst_n), .we_i(wr && bus_addr_i == A_NF_MASK),
        .wdata_i(bus_wdata_i), .q_o(mask_n));

    err_sev_out #(.W(DATA_W), .LATCH(1'b1)) i_out_f (
        .clk(clk), .rst_n(rst_n), .stat_i(stat_f), .mask_i(mask_f), .err_o(fatal_o));
    err_sev_out #(.W(DATA_W), .LATCH(1'b0)) i_out_n (
        .clk(clk), .rst_n(rst_n), .stat_i(stat_n), .mask_i(mask_n), .err_o(nonfatal_o));

    // Shared read mux for the bus and debug ports
    function automatic logic [DATA_W-1:0] rd_sel(logic [ADDR_W-1:0] a,
            logic [DATA_W-1:0] sf, logic [DATA_W-1:0] sn,
            logic [DATA_W-1:0] mf, logic [DATA_W-1:0] mn);
        case (a)
            A_FATAL_STAT: return sf;
            A_NF_STAT:    return sn;
            A_FATAL_MASK: return mf;
            default:      return mn;
        endcase
    endfunction

    // Combinational read data for both ports
    assign bus_rdata_o = rd_sel(bus_addr_i, stat_f, stat_n, mask_f, mask_n);
    assign dbg_rdata_o = rd_sel(dbg_addr_i, stat_f, stat_n, mask_f, mask_n);

    // R1
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_f[DATA_W-1:USED_W] == '0) && (stat_n[DATA_W-1:USED_W] == '0));
    // R7
    fatal_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_f & ~mask_f)) |=> fatal_o);
    // R8
    nonfatal_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_n & ~mask_n)) |=> nonfatal_o);
    // R8
    nonfatal_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_n & ~mask_n)) |=> !nonfatal_o);
    // R10
    always_comb begin
        if (rst_n && dbg_addr_i == bus_addr_i)
            port_agree_chk: assert (dbg_rdata_o == bus_rdata_o);
    end
endmodule

// File: tb/test_err_sev_aggregator.sv
module test_err_sev_aggregator;
    localparam logic [31:0] FM_RST = 32'h3F00_0000;
    localparam logic [31:0] NM_RST = 32'h00FF_F000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_err = 0, ecc_dbl = 0, ecc_sgl = 0;
    logic [2:0]  lc = '0;
    logic [4:0]  fuse = '0;
    logic [1:0]  rreq = '0;
    logic        bv = 0, bw = 0;
    logic [1:0]  ba = '0, da = '0;
    logic [31:0] bwd = '0;
    logic [31:0] brd, drd;
    logic        fat, nf;
    int          total = 0, bad = 0;

    always #4 clk = ~clk;

    err_sev_aggregator i_err_sev_aggregator (
        .clk(clk), .rst_n(rst_n), .core_err_i(core_err), .ecc_dbl_i(ecc_dbl),
        .ecc_sgl_i(ecc_sgl), .lc_alert_i(lc), .fuse_alert_i(fuse), .rst_req_i(rreq),
        .bus_valid_i(bv), .bus_write_i(bw), .bus_addr_i(ba), .bus_wdata_i(bwd),
        .bus_rdata_o(brd), .dbg_addr_i(da), .dbg_rdata_o(drd),
        .fatal_o(fat), .nonfatal_o(nf));

    task automatic tick(); @(negedge clk); endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        ba = a; #1; d = brd;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        bv = 1; bw = 1; ba = a; bwd = d;
        tick();
        bv = 0; bw = 0; bwd = '0;
    endtask

    task automatic srcs(logic [12:0] v);
        core_err = v[0]; ecc_dbl = v[1]; ecc_sgl = v[2];
        lc = v[5:3]; fuse = v[10:6]; rreq = v[12:11];
    endtask

    task automatic do_reset();
        srcs('0); bv = 0; bw = 0;
        rst_n = 0; tick(); tick(); rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d, ef, en;
        logic        fseen;
        tick();
        do_reset();
        // R5 reset state
        rd(0, d); chk("R5 fstat", d, 0);
        rd(1, d); chk("R5 nstat", d, 0);
        rd(2, d); chk("R5 fmask", d, FM_RST);
        rd(3, d); chk("R5 nmask", d, NM_RST);
        chk("R5 outs", {30'd0, fat, nf}, 0);

        // R1 exhaustive source routing, R7/R8 outputs with default masks
        fseen = 0;
        for (int v = 0; v < 8192; v++) begin
            logic [12:0] p;
            p = v[12:0];
            ef = 32'(p[0]) | (32'(p[1]) << 6) | (32'(p[5:3]) << 12)
               | (32'(p[10:6]) << 18) | (32'(p[12:11]) << 24);
            en = 32'(p[0]) | (32'(p[2]) << 6) | (32'(p[5:3]) << 12)
               | (32'(p[10:6]) << 18) | (32'(p[12:11]) << 24);
            srcs(p); tick(); srcs('0);
            rd(0, d); chk("R1 fatal map", d, ef);
            rd(1, d); chk("R1 nonfatal map", d, en);
            tick();
            fseen = fseen | ((ef & ~FM_RST) != 0);
            chk("R8 nonfatal out", 32'(nf), 32'((en & ~NM_RST) != 0));
            chk("R7 fatal out", 32'(fat), 32'(fseen));
            wr(0, '1); wr(1, '1); tick();
            chk("R3 cleared nf out", 32'(nf), 0);
        end

        // R2 sticky, R3 write-one-to-clear, R7 hold
        do_reset();
        core_err = 1; tick(); core_err = 0; tick(); tick();
        rd(0, d); chk("R2 sticky", d, 32'h1);
        chk("R7 raised", 32'(fat), 1);
        wr(0, 32'h0); rd(0, d); chk("R3 write zero", d, 32'h1);
        wr(0, 32'h2); rd(0, d); chk("R3 other bit", d, 32'h1);
        wr(0, 32'h1); rd(0, d); chk("R3 clear", d, 32'h0);
        wr(2, '1); tick(); tick();
        chk("R7 holds after clear and mask", 32'(fat), 1);
        rd(2, d); chk("R6 mask readback", d, 32'hFFFF_FFFF);

        // R4 set beats clear in the same cycle
        do_reset();
        core_err = 1; bv = 1; bw = 1; ba = 1; bwd = 32'h1;
        tick();
        core_err = 0; bv = 0; bw = 0; bwd = '0;
        rd(1, d); chk("R4 set wins", d, 32'h1);
        wr(1, 32'h1); rd(1, d); chk("R4 later clear", d, 32'h0);

        // R9 capture while masked, R8 deassert on mask and status writes
        do_reset();
        lc = 3'b001; tick(); lc = '0; tick();
        rd(1, d); chk("R9 captured masked", d, 32'h0000_1000);
        chk("R6 masked nf low", 32'(nf), 0);
        chk("R7 lc fatal", 32'(fat), 1);
        wr(3, 32'h0); tick(); chk("R9 unmask raises nf", 32'(nf), 1);
        wr(3, NM_RST); tick(); chk("R8 mask write drops nf", 32'(nf), 0);
        wr(3, 32'h0); tick(); chk("R8 reraise", 32'(nf), 1);
        wr(1, 32'h0000_1000); tick(); chk("R8 clear drops nf", 32'(nf), 0);

        // R9 on the fatal side: reset request masked by default
        do_reset();
        rreq = 2'b01; tick(); rreq = '0; tick();
        chk("R6 fatal masked", 32'(fat), 0);
        chk("R8 rreq nf", 32'(nf), 1);
        wr(2, 32'h0); tick(); chk("R9 fatal unmask", 32'(fat), 1);
        do_reset(); chk("R7 reset clears", 32'(fat), 0);

        // R10/R11 debug port agrees with bus per address
        wr(2, 32'h1234_5678); wr(3, 32'h8765_4321);
        ecc_sgl = 1; tick(); ecc_sgl = 0;
        for (int a = 0; a < 4; a++) begin
            logic [31:0] exp;
            exp = (a == 0) ? 32'h0 : (a == 1) ? 32'h40 : (a == 2) ? 32'h1234_5678 : 32'h8765_4321;
            da = a[1:0]; rd(a[1:0], d);
            chk("R11 bus read", d, exp);
            chk("R10 debug read", drd, exp);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule